// File: doc/BRIEF.md
# Synchronous SRAM Read-Output Pipeline and Deselect Control

This block owns the read-data return path and the output-drive enable of a synchronous SRAM port. Each rising clock edge captures one command: a read, a write, or a deselect. The array supplies the read word during the cycle after the command is captured. One configuration pin picks the data latency. In flow-through mode the array word goes straight to the data outputs. In pipelined mode it passes through one rising-edge output register, so a four-beat burst returns as 3-1-1-1 cycles instead of 2-1-1-1.

A second configuration pin sets how the output drivers turn off after reads. With single-cycle deselect, the drivers release as soon as the data slot that follows the last read holds a deselect. With dual-cycle deselect, the drivers stay on for one extra slot after the last read when that slot holds a deselect. Output-enable and sleep act on the drivers at once, without waiting for a clock edge. While sleep is high, the block also ignores new commands and freezes its output register. Both configuration pins are meant to be static: they are set up while reset is asserted.

Top module: `sram_rd_out_ctl`

## Requirements
- R1: While reset is asserted and after it is released with no command, `dq_oe` is low and, in pipelined mode, `dq_out` is all zeros.
- R2: With `cfg_pipe` = 0, a read captured at edge n makes the cycle after edge n the data slot: `dq_out` equals the current `arr_rdata` and `dq_oe` is high unless gated by R7 or R8.
- R3: With `cfg_pipe` = 1, a read captured at edge n makes the cycle after edge n+1 the data slot: `dq_out` equals the `arr_rdata` value present at edge n+1 and `dq_oe` is high unless gated.
- R4: With `cfg_dcd` = 0, `dq_oe` is low in any data slot that holds a deselect (`cmd_sel` = 0 or sleep high at capture), including a slot that directly follows a read.
- R5: With `cfg_dcd` = 1, a deselect slot that directly follows a read slot keeps `dq_oe` high for that one slot, and in pipelined mode `dq_out` still shows the last read word. A second deselect slot releases the drivers.
- R6: A data slot that holds a write (`cmd_sel` = 1, `cmd_wr` = 1) always has `dq_oe` low, even in dual-cycle mode right after a read.
- R7: `oe_n` high forces `dq_oe` low in the same cycle, with no clock edge needed, and changes no internal state.
- R8: `sleep` high forces `dq_oe` low in the same cycle. A command presented at an edge while sleep is high counts as a deselect, and the output register keeps its value across that edge.
- R9: Back-to-back reads give one new word in each consecutive data slot, with no gap, in both latency modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pipe | input | 1 | 1 = registered (pipelined) output, 0 = flow-through |
| cfg_dcd | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle deselect |
| cmd_sel | input | 1 | Chip selected for this edge's command |
| cmd_wr | input | 1 | Selected command is a write (0 = read) |
| sleep | input | 1 | Low-power request; gates drivers at once, blocks capture |
| oe_n | input | 1 | Asynchronous active-low output enable |
| arr_rdata | input | DATA_W | Array word for the command captured at the previous edge |
| dq_out | output | DATA_W | Read data toward the pads |
| dq_oe | output | 1 | Pad driver enable |

## Verification
The case that needs the most care is a slot where the dual-cycle hold could apply at the same time as a write or a new read. The test provokes it with read–write, read–deselect–read and read–deselect–deselect sequences in all four mode combinations. A reference queue model decides which rule wins: the write turns the drivers off, and the new read drives fresh data. A second overlap comes from `oe_n` or `sleep` changing during a held or live data slot. The model judges this by comparing `dq_oe` mid-cycle, in the same cycle the gate changes, and then confirms on the following slots that the pipeline state was not disturbed.

// File: rtl/sram_oq_pkg.sv
package sram_oq_pkg;

   // Kind of command sitting in one pipeline stage.
   typedef enum logic [1:0] {
      SLOT_DES = 2'd0,
      SLOT_RD  = 2'd1,
      SLOT_WR  = 2'd2
   } slot_e;

   // Classify the command at a capture edge; sleep turns anything into a deselect.
   function automatic slot_e classify(input logic sel, input logic wr, input logic slp);
      if (!sel || slp) return SLOT_DES;
      return wr ? SLOT_WR : SLOT_RD;
   endfunction

endpackage

// File: rtl/sram_oq_cmd_pipe.sv
module sram_oq_cmd_pipe
   import sram_oq_pkg::*;
#(
   parameter int STAGES = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmd_sel,
   input  logic  cmd_wr,
   input  logic  sleep,
   output slot_e stage_o [STAGES]
);

   slot_e stage_q [STAGES];

   generate
      if (STAGES < 3) begin : g_bad_depth
         $error("sram_oq_cmd_pipe needs at least three stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= SLOT_DES;
      end else begin
         stage_q[0] <= classify(cmd_sel, cmd_wr, sleep);
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   always_comb begin
      for (int i = 0; i < STAGES; i++) stage_o[i] = stage_q[i];
   end

endmodule

// File: rtl/sram_oq_data_reg.sv
module sram_oq_data_reg #(
   parameter int DATA_W         = 18,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] q_r;

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q_r <= '0;
            else if (load) q_r <= d;
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (load) q_r <= d;
         end
      end
   endgenerate

   assign q = q_r;

endmodule

// File: rtl/sram_oq_drive_ctl.sv
module sram_oq_drive_ctl
   import sram_oq_pkg::*;
(
   input  logic  cfg_pipe,
   input  logic  cfg_dcd,
   input  slot_e s_first,
   input  slot_e s_second,
   input  slot_e s_third,
   input  logic  oe_n,
   input  logic  sleep,
   output logic  dq_oe
);

   slot_e slot_now;
   slot_e slot_prev;
   logic  hold_extra;
   logic  drive_core;

   always_comb begin
      slot_now   = cfg_pipe ? s_second : s_first;
      slot_prev  = cfg_pipe ? s_third  : s_second;
      hold_extra = cfg_dcd && (slot_now == SLOT_DES) && (slot_prev == SLOT_RD);
      drive_core = (slot_now == SLOT_RD) || hold_extra;
      dq_oe      = drive_core && !oe_n && !sleep;
   end

endmodule

// File: rtl/sram_rd_out_ctl.sv
module sram_rd_out_ctl
   import sram_oq_pkg::*;
#(
   parameter int DATA_W         = 18,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pipe,
   input  logic              cfg_dcd,
   input  logic              cmd_sel,
   input  logic              cmd_wr,
   input  logic              sleep,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);

   localparam int STAGES = 3;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sram_rd_out_ctl: DATA_W must be positive");
      end
   endgenerate

   slot_e             stg [STAGES];
   logic [DATA_W-1:0] out_q;
   logic              out_load;

   sram_oq_cmd_pipe #(.STAGES(STAGES)) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_sel (cmd_sel),
      .cmd_wr  (cmd_wr),
      .sleep   (sleep),
      .stage_o (stg)
   );

   assign out_load = (stg[0] == SLOT_RD) && !sleep;

   sram_oq_data_reg #(.DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_oreg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (out_load),
      .d     (arr_rdata),
      .q     (out_q)
   );

   sram_oq_drive_ctl u_drv (
      .cfg_pipe (cfg_pipe),
      .cfg_dcd  (cfg_dcd),
      .s_first  (stg[0]),
      .s_second (stg[1]),
      .s_third  (stg[2]),
      .oe_n     (oe_n),
      .sleep    (sleep),
      .dq_oe    (dq_oe)
   );

   assign dq_out = cfg_pipe ? out_q : arr_rdata;

endmodule

// File: rtl/sram_rd_out_chk.sv
module sram_rd_out_chk #(
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_pipe,
   input logic              cfg_dcd,
   input logic              cmd_sel,
   input logic              cmd_wr,
   input logic              sleep,
   input logic              oe_n,
   input logic [DATA_W-1:0] arr_rdata,
   input logic [DATA_W-1:0] dq_out,
   input logic              dq_oe
);

   logic rd_req, wr_req, des_req;
   assign rd_req  = cmd_sel && !cmd_wr && !sleep;
   assign wr_req  = cmd_sel && cmd_wr && !sleep;
   assign des_req = !cmd_sel || sleep;

   // R2
   ft_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe && rd_req) |=> (dq_oe || oe_n || sleep));

   // R2
   ft_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe && rd_req) |=> (dq_out == arr_rdata));

   // R3
   pipe_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pipe && rd_req) |=> ##1 (dq_oe || oe_n || sleep));

   // R4
   ft_scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe && !cfg_dcd && des_req) |=> !dq_oe);

   // R4
   pipe_scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pipe && !cfg_dcd && des_req) |=> ##1 !dq_oe);

   // R5
   ft_dcd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe && cfg_dcd && rd_req) ##1 des_req |=> (dq_oe || oe_n || sleep));

   // R6
   ft_write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe && wr_req) |=> !dq_oe);

   // R6
   pipe_write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pipe && wr_req) |=> ##1 !dq_oe);

   // R7
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   // R8
   sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

endmodule

bind sram_rd_out_ctl sram_rd_out_chk #(.DATA_W(DATA_W)) u_rd_out_chk (.*);

// File: tb/test_sram_rd_out_ctl.sv
module test_sram_rd_out_ctl;

   localparam int W = 18;
   localparam int DES = 0, RD = 1, WR = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_pipe = 1'b1;
   logic         cfg_dcd = 1'b0;
   logic         cmd_sel = 1'b0;
   logic         cmd_wr = 1'b0;
   logic         sleep = 1'b0;
   logic         oe_n = 1'b0;
   logic [W-1:0] arr_rdata = '0;
   logic [W-1:0] dq_out;
   logic         dq_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state: commands by stage age, and the output register
   int           m1 = DES, m2 = DES, m3 = DES;
   logic [W-1:0] mq = '0;
   int           pat = 7;
   int           lfsr = 32'h1ACE;

   always #5 clk = ~clk;

   sram_rd_out_ctl #(.DATA_W(W)) i_sram_rd_out_ctl (
      .clk(clk), .rst_n(rst_n), .cfg_pipe(cfg_pipe), .cfg_dcd(cfg_dcd),
      .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .sleep(sleep), .oe_n(oe_n),
      .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1 = DES; m2 = DES; m3 = DES; mq = '0;
      end else begin
         if (m1 == RD && !sleep) mq = arr_rdata;
         m3 = m2;
         m2 = m1;
         m1 = (!cmd_sel || sleep) ? DES : (cmd_wr ? WR : RD);
      end
   end

   task automatic check_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s dq_oe actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s dq_out actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      int    slot, prev;
      bit    hold, core, exp_oe;
      string tag;
      slot   = cfg_pipe ? m2 : m1;
      prev   = cfg_pipe ? m3 : m2;
      hold   = cfg_dcd && slot == DES && prev == RD;
      core   = (slot == RD) || hold;
      exp_oe = core && !oe_n && !sleep;
      if (sleep)                tag = "R8";
      else if (oe_n)            tag = "R7";
      else if (slot == WR)      tag = "R6";
      else if (hold)            tag = "R5";
      else if (slot == DES)     tag = "R4";
      else                      tag = cfg_pipe ? "R3/R9" : "R2/R9";
      check_bit(tag, dq_oe, exp_oe);
      if (slot == RD)
         check_word(cfg_pipe ? "R3" : "R2", dq_out, cfg_pipe ? mq : arr_rdata);
      else if (hold && cfg_pipe)
         check_word("R5", dq_out, mq);
   endtask

   // one cycle: drive new inputs after the falling edge, then compare mid-cycle
   task automatic step(input bit sel, input bit wr, input bit oen, input bit slp);
      @(negedge clk);
      cmd_sel   = sel;
      cmd_wr    = wr;
      oe_n      = oen;
      sleep     = slp;
      pat       = pat * 37 + 11;
      arr_rdata = W'(pat);
      #1;
      compare();
   endtask

   task automatic run_mode(input bit pipe, input bit dcd);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_pipe = pipe;
      cfg_dcd = dcd;
      cmd_sel = 0; cmd_wr = 0; oe_n = 0; sleep = 0;
      #1;
      // R1 during reset
      check_bit("R1", dq_oe, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check_bit("R1", dq_oe, 1'b0);
      if (pipe) check_word("R1", dq_out, '0);
      // R9 burst of four reads
      repeat (4) step(1, 0, 0, 0);
      // R4/R5 read then deselects
      step(0, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      // R6 read followed by write
      step(1, 0, 0, 0); step(1, 1, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
      // R5 hold slot meets new read
      step(1, 0, 0, 0); step(0, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0);
      step(0, 0, 0, 0); step(0, 0, 0, 0);
      // R7 output enable toggling over live slots
      step(1, 0, 0, 0); step(1, 0, 1, 0); step(1, 0, 0, 0); step(0, 0, 1, 0);
      step(0, 0, 0, 0); step(0, 0, 0, 0);
      // R8 sleep over a read stream; selected commands ignored
      step(1, 0, 0, 0); step(1, 0, 0, 1); step(1, 0, 0, 1); step(0, 0, 0, 0);
      step(0, 0, 0, 0); step(0, 0, 0, 0);
      // mixed traffic
      for (int k = 0; k < 80; k++) begin
         bit s, w, o, z;
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
         s = lfsr[0] | lfsr[1];
         w = lfsr[2] & lfsr[3];
         o = lfsr[4] & lfsr[5] & lfsr[6];
         z = (lfsr[9:7] == 3'b000);
         step(s, w, o, z);
      end
      repeat (3) step(0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      run_mode(1, 0);
      run_mode(1, 1);
      run_mode(0, 0);
      run_mode(0, 1);
      finish_run();
   end

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule